// File: doc/BRIEF.md
# Miss-Cost-Weighted Cache Replacement Selector

This block chooses which way of a set-associative cache to evict. Each way of each set carries a saturating benefit counter. The counter estimates how many processor stall cycles the line has saved by staying resident. Each hit adds a weight to the counter. The weight depends on how costly a miss of that kind would have been. An isolated instruction fetch or load scores highest. A fetch or load that overlaps other outstanding misses scores lower, and a store scores lowest.

On a fill, the counter of the way being written is seeded with the same weight, multiplied by a bucket taken from the measured miss latency. Slow misses therefore give a line a longer head start. On a miss the victim is the way with the smallest counter. Any empty way is taken first.

The cache controller presents one access per cycle, together with the set index, the access kind, hit or miss, the hit way, an overlap flag and the observed latency. The block returns the victim for the addressed set in the same cycle. It commits the counter update on the next clock edge and exposes the addressed set's counters and valid bits.

Top module: `rbr_repl_top`

## Requirements
- R1: After reset every way of every set is invalid with a counter of 0, so `victimWay` is 0 and `victimFree` is 1 for any set.
- R2: `reqKind` is encoded as 0 = instruction fetch, 1 = load, 2 = store, 3 = treated as store. The weight is 4 for a fetch or load with `reqOverlap` low, 2 for a fetch or load with `reqOverlap` high, and 1 for any store regardless of overlap.
- R3: A hit (`reqValid` and `reqHit` high) adds the weight to the counter of way `reqWay` in set `reqSet`. The new value is visible on `setBenefit` one cycle later. Other ways are unchanged unless R7 applies.
- R4: A miss fills the current victim way. Its counter becomes weight × bucket, where bucket = `reqLatency` >> 4 clamped to the range 1..7, and the way becomes valid.
- R5: When the addressed set has an invalid way, the victim is the lowest-numbered invalid way and `victimFree` is 1.
- R6: When all ways are valid, the victim is the way with the smallest counter, ties going to the lowest way index, and `victimFree` is 0.
- R7: If an update would make a counter reach or exceed 255, that counter is written as 127 and every other counter in the same set is halved (rounded down) on the same edge.
- R8: An update changes only the counters and valid bits of the set named by `reqSet`.
- R9: With `reqValid` low no state changes, whatever the other request inputs are. On a miss, `reqWay` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| reqSet | input | 4 | Set index used both for lookup and for update |
| reqKind | input | 2 | Access kind (encoding in R2) |
| reqHit | input | 1 | 1 = hit, 0 = miss with fill |
| reqWay | input | 2 | Hit way; ignored on a miss |
| reqOverlap | input | 1 | Miss overlaps other outstanding misses |
| reqLatency | input | 8 | Observed miss latency in cycles |
| victimWay | output | 2 | Way to evict in the addressed set |
| victimFree | output | 1 | Victim way is currently invalid |
| setValid | output | 4 | Valid bits of the addressed set, one per way |
| setBenefit | output | 32 | Counters of the addressed set, way w in bits [8w+7:8w] |

## Verification
The assertions assume the controller reports a hit only for a way that already holds a valid line. They also assume that the way filled on a miss is the victim the block itself offers in that cycle. The bench keeps to both assumptions. It mirrors the valid bits in its own model and only issues hits to ways that model has filled. Every miss is left to land in the block's own choice. Checks are made from the ports a half cycle after each update edge, so that a saturation event is observed together with its effect on the rest of the set.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_SPARE = 2'd3
  } accKind_e;

  typedef struct packed {
    logic doHit;
    logic doFill;
  } updStrobe_t;

endpackage

// File: rtl/rbr_ctrl.sv
module rbr_ctrl
  import rbr_pkg::*;
#(
  parameter int NUM_WAYS     = 4,
  parameter int CNT_W        = 8,
  parameter int LAT_W        = 8,
  parameter int BUCKET_SHIFT = 4,
  parameter int BUCKET_MAX   = 7,
  parameter int W_HIGH       = 4,
  parameter int W_MED        = 2,
  parameter int W_LOW        = 1,
  localparam int WAY_W       = $clog2(NUM_WAYS)
) (
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqHit,
  input  logic [WAY_W-1:0] reqWay,
  input  logic             reqOverlap,
  input  logic [LAT_W-1:0] reqLatency,
  input  logic [WAY_W-1:0] victimWay,
  output updStrobe_t       strobe,
  output logic [WAY_W-1:0] updWay,
  output logic [CNT_W-1:0] amount
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  accKind_e    kind;
  int unsigned weight;
  int unsigned bucket;
  int unsigned product;

  assign kind = accKind_e'(reqKind);

  always_comb begin
    unique case (kind)
      KIND_FETCH, KIND_LOAD: weight = reqOverlap ? W_MED : W_HIGH;
      default:               weight = W_LOW;
    endcase
  end

  always_comb begin
    bucket = 32'(reqLatency) >> BUCKET_SHIFT;
    if (bucket < 1) bucket = 1;
    if (bucket > BUCKET_MAX) bucket = BUCKET_MAX;
  end

  always_comb begin
    product = reqHit ? weight : weight * bucket;
    amount  = (product > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(product);
  end

  assign strobe.doHit  = reqValid && reqHit;
  assign strobe.doFill = reqValid && !reqHit;
  assign updWay        = reqHit ? reqWay : victimWay;

endmodule

// File: rtl/rbr_victim_tree.sv
module rbr_victim_tree #(
  parameter int NUM_WAYS = 4,
  parameter int KEY_W    = 9,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int LEVELS  = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][KEY_W-1:0] keys,
  output logic [WAY_W-1:0]               minWay
);

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int NODES = NUM_WAYS >> l;
    logic [KEY_W-1:0] key [NODES];
    logic [WAY_W-1:0] idx [NODES];
    if (l == 0) begin : g_leaf
      for (genvar w = 0; w < NODES; w++) begin : g_w
        assign key[w] = keys[w];
        assign idx[w] = WAY_W'(w);
      end
    end else begin : g_node
      for (genvar n = 0; n < NODES; n++) begin : g_n
        logic pickLeft;
        assign pickLeft = lvl[l-1].key[2*n] <= lvl[l-1].key[2*n+1];
        assign key[n]   = pickLeft ? lvl[l-1].key[2*n] : lvl[l-1].key[2*n+1];
        assign idx[n]   = pickLeft ? lvl[l-1].idx[2*n] : lvl[l-1].idx[2*n+1];
      end
    end
  end

  assign minWay = lvl[LEVELS].idx[0];

endmodule

// File: rtl/rbr_datapath.sv
module rbr_datapath
  import rbr_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int KEY_W   = CNT_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SET_W-1:0]              reqSet,
  input  updStrobe_t                    strobe,
  input  logic [WAY_W-1:0]              updWay,
  input  logic [CNT_W-1:0]              amount,
  output logic [WAY_W-1:0]              victimWay,
  output logic                          victimFree,
  output logic [NUM_WAYS-1:0]           setValid,
  output logic [NUM_WAYS*CNT_W-1:0]     setBenefit
);

  localparam logic [CNT_W:0]   SUM_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] HALF    = {1'b0, {(CNT_W-1){1'b1}}};

  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] cntQ;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            validQ;

  logic                          upd;
  logic [CNT_W-1:0]              curCnt;
  logic [CNT_W:0]                sum;
  logic                          sat;
  logic [NUM_WAYS-1:0][KEY_W-1:0] keyOf;

  assign upd    = strobe.doHit || strobe.doFill;
  assign curCnt = cntQ[reqSet][updWay];
  assign sum    = (strobe.doFill ? '0 : {1'b0, curCnt}) + {1'b0, amount};
  assign sat    = sum >= SUM_MAX;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_key
    assign keyOf[w] = {validQ[reqSet][w], cntQ[reqSet][w]};
    assign setBenefit[w*CNT_W +: CNT_W] = cntQ[reqSet][w];
  end

  rbr_victim_tree #(
    .NUM_WAYS (NUM_WAYS),
    .KEY_W    (KEY_W)
  ) u_tree (
    .keys   (keyOf),
    .minWay (victimWay)
  );

  assign victimFree = !validQ[reqSet][victimWay];
  assign setValid   = validQ[reqSet];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      validQ <= '0;
    end else if (upd) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == updWay) begin
          cntQ[reqSet][w] <= sat ? HALF : sum[CNT_W-1:0];
        end else if (sat) begin
          cntQ[reqSet][w] <= cntQ[reqSet][w] >> 1;
        end
      end
      if (strobe.doFill) validQ[reqSet][updWay] <= 1'b1;
    end
  end

  // R3: an unsaturated hit adds exactly the amount to the hit way
  a_r3_hit_adds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doHit && !sat) |=>
      cntQ[$past(reqSet)][$past(updWay)] == CNT_W'($past(curCnt) + $past(amount)));

  // R4: a filled way is valid afterwards
  a_r4_fill_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doFill |=> validQ[$past(reqSet)][$past(updWay)]);

  // R5: any empty way makes the victim an empty way
  a_r5_free_first: assert property (@(posedge clk) disable iff (!rstN)
    !(&validQ[reqSet]) |-> victimFree);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk
    // R6: victim key is not larger than any other way's key
    a_r6_victim_min: assert property (@(posedge clk) disable iff (!rstN)
      keyOf[victimWay] <= keyOf[w]);
    // R6: every lower way is strictly worse than the victim
    a_r6_tie_lowest: assert property (@(posedge clk) disable iff (!rstN)
      (WAY_W'(w) < victimWay) |-> (keyOf[w] > keyOf[victimWay]));
    // R7: after a saturating update no counter in that set exceeds half
    a_r7_sat_halves: assert property (@(posedge clk) disable iff (!rstN)
      (upd && sat) |=> cntQ[$past(reqSet)][w] <= HALF);
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    // R8 and R9: sets not addressed by an update keep their counters
    a_r8_other_sets: assert property (@(posedge clk) disable iff (!rstN)
      !(upd && reqSet == SET_W'(s)) |=> $stable(cntQ[s]) && $stable(validQ[s]));
  end

endmodule

// File: rtl/rbr_repl_top.sv
module rbr_repl_top
  import rbr_pkg::*;
#(
  parameter int NUM_SETS     = 16,
  parameter int NUM_WAYS     = 4,
  parameter int CNT_W        = 8,
  parameter int LAT_W        = 8,
  parameter int BUCKET_SHIFT = 4,
  parameter int BUCKET_MAX   = 7,
  parameter int W_HIGH       = 4,
  parameter int W_MED        = 2,
  parameter int W_LOW        = 1,
  localparam int SET_W       = $clog2(NUM_SETS),
  localparam int WAY_W       = $clog2(NUM_WAYS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic [SET_W-1:0]          reqSet,
  input  logic [1:0]                reqKind,
  input  logic                      reqHit,
  input  logic [WAY_W-1:0]          reqWay,
  input  logic                      reqOverlap,
  input  logic [LAT_W-1:0]          reqLatency,
  output logic [WAY_W-1:0]          victimWay,
  output logic                      victimFree,
  output logic [NUM_WAYS-1:0]       setValid,
  output logic [NUM_WAYS*CNT_W-1:0] setBenefit
);

  updStrobe_t       strobe;
  logic [WAY_W-1:0] updWay;
  logic [CNT_W-1:0] amount;

  rbr_ctrl #(
    .NUM_WAYS     (NUM_WAYS),
    .CNT_W        (CNT_W),
    .LAT_W        (LAT_W),
    .BUCKET_SHIFT (BUCKET_SHIFT),
    .BUCKET_MAX   (BUCKET_MAX),
    .W_HIGH       (W_HIGH),
    .W_MED        (W_MED),
    .W_LOW        (W_LOW)
  ) u_ctrl (
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqHit     (reqHit),
    .reqWay     (reqWay),
    .reqOverlap (reqOverlap),
    .reqLatency (reqLatency),
    .victimWay  (victimWay),
    .strobe     (strobe),
    .updWay     (updWay),
    .amount     (amount)
  );

  rbr_datapath #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqSet     (reqSet),
    .strobe     (strobe),
    .updWay     (updWay),
    .amount     (amount),
    .victimWay  (victimWay),
    .victimFree (victimFree),
    .setValid   (setValid),
    .setBenefit (setBenefit)
  );

endmodule

// File: tb/rbr_repl_top_tb.sv
`timescale 1ns/1ps
module rbr_repl_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [3:0] reqSet = '0;
  logic [1:0] reqKind = '0;
  logic       reqHit = 1'b0;
  logic [1:0] reqWay = '0;
  logic       reqOverlap = 1'b0;
  logic [7:0] reqLatency = '0;
  logic [1:0] victimWay;
  logic       victimFree;
  logic [3:0] setValid;
  logic [31:0] setBenefit;

  int checks = 0;
  int errors = 0;
  int mCnt [16][4];
  bit mVal [16][4];

  always #2 clk = ~clk;

  rbr_repl_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSet(reqSet),
    .reqKind(reqKind), .reqHit(reqHit), .reqWay(reqWay),
    .reqOverlap(reqOverlap), .reqLatency(reqLatency),
    .victimWay(victimWay), .victimFree(victimFree),
    .setValid(setValid), .setBenefit(setBenefit)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wgt(int kind, bit ovl);
    if (kind <= 1) return ovl ? 2 : 4;
    return 1;
  endfunction

  function automatic int bkt(int lat);
    int b = lat >> 4;
    if (b < 1) b = 1;
    if (b > 7) b = 7;
    return b;
  endfunction

  function automatic int mVictim(int s);
    int best = 0;
    for (int w = 0; w < 4; w++) if (!mVal[s][w]) return w;
    for (int w = 1; w < 4; w++) if (mCnt[s][w] < mCnt[s][best]) best = w;
    return best;
  endfunction

  task automatic checkSet(int s, string tag);
    reqSet = 4'(s);
    #1;
    for (int w = 0; w < 4; w++) begin
      chk({tag, " counter"}, int'(setBenefit[w*8 +: 8]), mCnt[s][w]);
      chk({tag, " valid"}, int'(setValid[w]), int'(mVal[s][w]));
    end
  endtask

  task automatic access(int s, int kind, bit hit, int way, bit ovl, int lat, string tag);
    int tgt;
    int val;
    @(negedge clk);
    reqValid = 1'b1; reqSet = 4'(s); reqKind = 2'(kind); reqHit = hit;
    reqWay = 2'(way); reqOverlap = ovl; reqLatency = 8'(lat);
    #1;
    if (!hit) begin
      chk({tag, " victim R5 R6"}, int'(victimWay), mVictim(s));
      chk({tag, " victimFree R5 R6"}, int'(victimFree), int'(!mVal[s][mVictim(s)]));
    end
    tgt = hit ? way : mVictim(s);
    val = hit ? mCnt[s][tgt] + wgt(kind, ovl) : wgt(kind, ovl) * bkt(lat);
    if (val >= 255) begin
      for (int w = 0; w < 4; w++) mCnt[s][w] = mCnt[s][w] >> 1;
      val = 127;
    end
    mCnt[s][tgt] = val;
    if (!hit) mVal[s][tgt] = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkSet(s, tag);
  endtask

  task automatic tResetState();
    for (int s = 0; s < 16; s += 5) begin
      checkSet(s, "R1 reset");
      chk("R1 victimWay", int'(victimWay), 0);
      chk("R1 victimFree", int'(victimFree), 1);
    end
  endtask

  task automatic tFillOrder();
    access(0, 0, 0, 3, 0, 40,  "R4 fetch fill");
    access(0, 1, 0, 3, 1, 5,   "R4 overlapped load fill");
    access(0, 2, 0, 0, 1, 200, "R4 store fill");
    access(0, 1, 0, 0, 0, 100, "R4 load fill");
    chk("R4 way0", int'(setBenefit[7:0]), 8);
    chk("R4 way1", int'(setBenefit[15:8]), 2);
    chk("R4 way2", int'(setBenefit[23:16]), 7);
    chk("R4 way3", int'(setBenefit[31:24]), 24);
    chk("R6 min victim", int'(victimWay), 1);
    chk("R6 victimFree", int'(victimFree), 0);
  endtask

  task automatic tHitWeights();
    access(0, 2, 1, 1, 0, 0, "R3 store hit");
    access(0, 0, 1, 0, 1, 0, "R2 overlapped fetch hit");
    access(0, 3, 1, 2, 0, 0, "R2 spare kind as store");
    chk("R2 spare weight", int'(setBenefit[23:16]), 8);
    chk("R3 way0", int'(setBenefit[7:0]), 10);
  endtask

  task automatic tTieBreak();
    access(0, 1, 1, 1, 0, 0, "R3 isolated load hit");
    access(0, 2, 1, 1, 1, 0, "R3 store hit overlap");
    chk("R6 tie value", int'(setBenefit[15:8]), 8);
    chk("R6 tie lowest way", int'(victimWay), 1);
  endtask

  task automatic tReplaceMin();
    access(0, 2, 0, 0, 0, 16, "R6 replace min");
    chk("R6 replaced way1", int'(setBenefit[15:8]), 1);
  endtask

  task automatic tMissWayIgnored();
    access(2, 0, 0, 3, 0, 0, "R9 miss way ignored");
    chk("R9 fill went to way0", int'(setValid), 1);
  endtask

  task automatic tSaturation();
    access(1, 0, 0, 0, 0, 255, "R7 setup fill a");
    access(1, 1, 0, 0, 0, 50,  "R7 setup fill b");
    for (int i = 0; i < 56; i++) access(1, 0, 1, 0, 0, 0, "R7 ramp");
    access(1, 2, 1, 0, 0, 0, "R7 ramp store");
    access(1, 2, 1, 0, 0, 0, "R7 ramp store");
    chk("R7 below limit", int'(setBenefit[7:0]), 254);
    access(1, 2, 1, 0, 0, 0, "R7 saturating hit");
    chk("R7 saturated way", int'(setBenefit[7:0]), 127);
    chk("R7 halved neighbour", int'(setBenefit[15:8]), 6);
  endtask

  task automatic tIdleIgnored();
    @(negedge clk);
    reqValid = 1'b0; reqSet = 4'd0; reqHit = 1'b1; reqWay = 2'd3;
    reqKind = 2'd0; reqLatency = 8'd255;
    repeat (4) @(negedge clk);
    reqHit = 1'b0;
    repeat (3) @(negedge clk);
    checkSet(0, "R9 idle");
    checkSet(1, "R8 isolation set1");
    checkSet(0, "R8 isolation set0");
    checkSet(7, "R8 untouched set");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-all actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tFillOrder();
    tHitWeights();
    tTieBreak();
    tReplaceMin();
    tMissWayIgnored();
    tSaturation();
    tIdleIgnored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule